// File: doc/BRIEF.md
# Clock Ratio Configuration Controller

This block holds the settings that shape a clock subsystem. It stores a VCO multiplier select, a flag that halves the reference input, a core clock divider select and a system clock divider select. Software writes these over a small register bus with two addresses. The first address holds the multiplier and the halving flag. The second holds both divider selects.

Divider selects take effect on the clock edge that accepts the write. A divider write can never leave the system clock faster than the core clock. Instead of faulting, the block raises the stored system ratio to the core ratio, and software sees the adjusted value when it reads the register back. Multiplier settings go into a staged copy first. They move into the active setting only on a one-cycle apply strobe, which stands in for a relock sequence. A busy flag then stays high for a fixed number of cycles.

The block reports the effective VCO multiple in half units, so that halved odd multiples stay exact. It also reports both effective divide ratios. From a reference tick input it derives one clock-enable pulse for the core domain and one for the system domain.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the divider register reads 0x0040 (core select 0, system field 4), `core_ratio` is 1, `sys_ratio` is 4, `busy` is low, the control register reads 0x000A and `vco_mult_x2` is 20.
- R2: The core select in divider register bits [1:0] encodes ratios 1, 2, 4 and 8 for values 0, 1, 2 and 3.
- R3: The system select in divider register bits [7:4] encodes ratio N for N from 1 to 15, and a value of 0 is treated as 1.
- R4: The effective system ratio is never below the core ratio. A write that asks for less stores the core ratio, and readback of bits [7:4] returns the stored effective value.
- R5: A divider write changes `core_ratio` and `sys_ratio` on the clock edge that accepts it. Nothing else changes them.
- R6: A control write (multiplier select in bits [5:0], halving flag in bit 8) updates only the staged copy, which reads back at address 0. `vco_mult_x2` keeps its value until an apply strobe is accepted.
- R7: An apply strobe taken while `busy` is low copies the staged value into the active setting and holds `busy` high for exactly 16 cycles. An apply strobe during `busy` is ignored.
- R8: `vco_mult_x2` is twice the multiple: a select of 0 means 64 and N means N, and the halving flag divides the result by two (select 63 with the flag gives 63, select 0 with the flag gives 64).
- R9: Each enable output pulses once for every ratio reference ticks. Each pulse lasts one cycle and follows the tick that completes the count by one cycle.
- R10: When an effective ratio changes, its enable counter restarts, so the first pulse comes on the ratio-th tick after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the divider register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Readback of the addressed register (staged control or effective dividers) |
| apply | input | 1 | Single-cycle strobe that commits the staged multiplier setting |
| ref_tick | input | 1 | Reference tick that the enable dividers count |
| busy | output | 1 | High during the relock interval |
| vco_mult_x2 | output | 8 | Effective VCO multiple in half units |
| core_ratio | output | 4 | Effective core divide ratio |
| sys_ratio | output | 4 | Effective system divide ratio |
| core_en | output | 1 | Core clock-enable pulse |
| sys_en | output | 1 | System clock-enable pulse |

## Verification
A wrong stored divider shows up on `core_ratio`, `sys_ratio` and the readback one cycle after the write. A wrong enable count appears as a wrong pulse count within one ratio period of ticks. A staging fault is visible at once, because `vco_mult_x2` changes without an apply or stays put after one. A relock counter that is off by one shows as a `busy` window of the wrong length, and this is seen on the first apply. The bench counts pulses over whole ratio periods and counts `busy` cycles one by one, so all of these faults surface within a few dozen cycles of their cause.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
   // register addresses on the configuration bus
   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_DIV  = 1'b1
   } reg_addr_e;

   // field positions other logic decodes
   localparam int unsigned CTRL_HALF_BIT = 8;
   localparam int unsigned DIV_SYS_LSB   = 4;
endpackage

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
   import clk_ratio_pkg::*;
#(
   parameter int unsigned MULT_W        = 6,
   parameter int unsigned CORE_SEL_W    = 2,
   parameter int unsigned SYS_SEL_W     = 4,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned RELOCK_CYCLES = 16,
   parameter int unsigned RST_MULT      = 10,
   parameter int unsigned RST_SYS       = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic                 addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   input  logic                 apply_i,
   output logic                 busy_o,
   output logic [MULT_W-1:0]    mult_sel_o,
   output logic                 half_o,
   output logic [SYS_SEL_W-1:0] core_ratio_o,
   output logic [SYS_SEL_W-1:0] sys_ratio_o
);
   localparam int unsigned RATIO_W = SYS_SEL_W;
   localparam int unsigned CNT_W   = $clog2(RELOCK_CYCLES + 1);

   logic [MULT_W-1:0]     shd_mult_q, act_mult_q;
   logic                  shd_half_q, act_half_q;
   logic [CORE_SEL_W-1:0] core_sel_q;
   logic [RATIO_W-1:0]    sys_q;
   logic [CNT_W-1:0]      relock_q;

   logic [CORE_SEL_W-1:0] wr_core_sel;
   logic [RATIO_W-1:0]    wr_core_ratio, wr_sys_raw, wr_sys_req, wr_sys_eff;
   logic                  wr_ctrl, wr_div, apply_ok;

   always_comb begin
      wr_core_sel   = wdata_i[CORE_SEL_W-1:0];
      wr_core_ratio = RATIO_W'(1) << wr_core_sel;
      wr_sys_raw    = wdata_i[DIV_SYS_LSB +: SYS_SEL_W];
      wr_sys_req    = (wr_sys_raw == '0) ? RATIO_W'(1) : wr_sys_raw;
      wr_sys_eff    = (wr_sys_req < wr_core_ratio) ? wr_core_ratio : wr_sys_req;
      wr_ctrl       = wr_i && (addr_i == ADDR_CTRL);
      wr_div        = wr_i && (addr_i == ADDR_DIV);
      apply_ok      = apply_i && (relock_q == '0);
   end

   // staged and active multiplier settings
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_mult_q <= MULT_W'(RST_MULT);
         shd_half_q <= 1'b0;
         act_mult_q <= MULT_W'(RST_MULT);
         act_half_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            shd_mult_q <= wdata_i[MULT_W-1:0];
            shd_half_q <= wdata_i[CTRL_HALF_BIT];
         end
         if (apply_ok) begin
            act_mult_q <= shd_mult_q;
            act_half_q <= shd_half_q;
         end
      end
   end

   // relock interval counter
   always_ff @(posedge clk) begin
      if (!rst_n)             relock_q <= '0;
      else if (apply_ok)      relock_q <= CNT_W'(RELOCK_CYCLES);
      else if (relock_q != '0) relock_q <= relock_q - 1'b1;
   end

   // divider register stores the clamped system ratio
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_sel_q <= '0;
         sys_q      <= RATIO_W'(RST_SYS);
      end else if (wr_div) begin
         core_sel_q <= wr_core_sel;
         sys_q      <= wr_sys_eff;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_CTRL) begin
         rdata_o[MULT_W-1:0]    = shd_mult_q;
         rdata_o[CTRL_HALF_BIT] = shd_half_q;
      end else begin
         rdata_o[CORE_SEL_W-1:0]             = core_sel_q;
         rdata_o[DIV_SYS_LSB +: SYS_SEL_W]   = sys_q;
      end
   end

   assign busy_o       = (relock_q != '0);
   assign mult_sel_o   = act_mult_q;
   assign half_o       = act_half_q;
   assign core_ratio_o = RATIO_W'(1) << core_sel_q;
   assign sys_ratio_o  = sys_q;
endmodule

// File: rtl/clk_en_div.sv
module clk_en_div #(
   parameter int unsigned RATIO_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               en_o
);
   logic [RATIO_W-1:0] cnt_q, ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= '0;
         en_o    <= 1'b0;
      end else if (ratio_i != ratio_q) begin
         // ratio changed: restart the count from zero
         ratio_q <= ratio_i;
         cnt_q   <= '0;
         en_o    <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == ratio_q - 1'b1) begin
            cnt_q <= '0;
            en_o  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            en_o  <= 1'b0;
         end
      end else begin
         en_o <= 1'b0;
      end
   end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl #(
   parameter int unsigned MULT_W        = 6,
   parameter int unsigned CORE_SEL_W    = 2,
   parameter int unsigned SYS_SEL_W     = 4,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned RELOCK_CYCLES = 16,
   parameter int unsigned RST_MULT      = 10,
   parameter int unsigned RST_SYS       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   input  logic                   apply,
   input  logic                   ref_tick,
   output logic                   busy,
   output logic [MULT_W+1:0]      vco_mult_x2,
   output logic [SYS_SEL_W-1:0]   core_ratio,
   output logic [SYS_SEL_W-1:0]   sys_ratio,
   output logic                   core_en,
   output logic                   sys_en
);
   localparam int unsigned RATIO_W  = SYS_SEL_W;
   localparam int unsigned MAX_CORE = 1 << ((1 << CORE_SEL_W) - 1);
   localparam int unsigned N_DIV    = 2;

   // elaboration-time parameter checks
   if (MAX_CORE > (1 << RATIO_W) - 1) begin : g_bad_core_w
      $error("core ratio range does not fit the system ratio width");
   end
   if (DATA_W < clk_ratio_pkg::CTRL_HALF_BIT + 1 ||
       DATA_W < clk_ratio_pkg::DIV_SYS_LSB + SYS_SEL_W ||
       MULT_W > clk_ratio_pkg::CTRL_HALF_BIT) begin : g_bad_data_w
      $error("register fields do not fit the data width");
   end
   if (RELOCK_CYCLES < 1 || RST_SYS < 1 || RST_SYS >= (1 << SYS_SEL_W)) begin : g_bad_rst
      $error("relock length or reset system ratio out of range");
   end

   logic [MULT_W-1:0] mult_sel;
   logic              half;
   logic [MULT_W:0]   mult_full;

   clk_ratio_regs #(
      .MULT_W(MULT_W), .CORE_SEL_W(CORE_SEL_W), .SYS_SEL_W(SYS_SEL_W),
      .DATA_W(DATA_W), .RELOCK_CYCLES(RELOCK_CYCLES),
      .RST_MULT(RST_MULT), .RST_SYS(RST_SYS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
      .apply_i(apply), .busy_o(busy),
      .mult_sel_o(mult_sel), .half_o(half),
      .core_ratio_o(core_ratio), .sys_ratio_o(sys_ratio)
   );

   // select 0 stands for the full power of two
   always_comb begin
      mult_full   = (mult_sel == '0) ? (MULT_W+1)'(1 << MULT_W) : {1'b0, mult_sel};
      vco_mult_x2 = half ? {1'b0, mult_full} : {mult_full, 1'b0};
   end

   logic [RATIO_W-1:0] div_ratio [N_DIV];
   logic [N_DIV-1:0]   div_en;
   assign div_ratio[0] = core_ratio;
   assign div_ratio[1] = sys_ratio;

   for (genvar g = 0; g < N_DIV; g++) begin : g_div
      clk_en_div #(.RATIO_W(RATIO_W)) u_div (
         .clk(clk), .rst_n(rst_n), .tick_i(ref_tick),
         .ratio_i(div_ratio[g]), .en_o(div_en[g])
      );
   end

   assign core_en = div_en[0];
   assign sys_en  = div_en[1];
endmodule

// File: rtl/clk_ratio_chk.sv
module clk_ratio_chk #(
   parameter int unsigned SYS_SEL_W     = 4,
   parameter int unsigned MULT_W        = 6,
   parameter int unsigned RELOCK_CYCLES = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic                 reg_addr,
   input logic                 apply,
   input logic                 ref_tick,
   input logic                 busy,
   input logic [MULT_W+1:0]    vco_mult_x2,
   input logic [SYS_SEL_W-1:0] core_ratio,
   input logic [SYS_SEL_W-1:0] sys_ratio,
   input logic                 core_en,
   input logic                 sys_en
);
   localparam int unsigned CW = $clog2(RELOCK_CYCLES + 2);
   logic [CW-1:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   assert_sys_ge_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sys_ratio >= core_ratio);

   assert_ratio_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_wr && reg_addr) |-> ($stable(core_ratio) && $stable(sys_ratio)));

   assert_vco_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(apply) || $past(busy)) |-> $stable(vco_mult_x2));

   assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < CW'(RELOCK_CYCLES)));

   assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(busy_len) == CW'(RELOCK_CYCLES - 1)));

   assert_core_en_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |-> $past(ref_tick));

   assert_sys_en_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_en |-> $past(ref_tick));
endmodule

bind clk_ratio_ctrl clk_ratio_chk #(
   .SYS_SEL_W(SYS_SEL_W), .MULT_W(MULT_W), .RELOCK_CYCLES(RELOCK_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .apply(apply), .ref_tick(ref_tick), .busy(busy), .vco_mult_x2(vco_mult_x2),
   .core_ratio(core_ratio), .sys_ratio(sys_ratio),
   .core_en(core_en), .sys_en(sys_en)
);

// File: tb/tb_clk_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_clk_ratio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        apply = 1'b0;
   logic        ref_tick = 1'b0;
   logic        busy;
   logic [7:0]  vco_mult_x2;
   logic [3:0]  core_ratio, sys_ratio;
   logic        core_en, sys_en;

   int errors = 0;
   int checks = 0;
   int core_pulses = 0;
   int sys_pulses = 0;

   always #10 clk = ~clk;

   clk_ratio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apply(apply),
      .ref_tick(ref_tick), .busy(busy), .vco_mult_x2(vco_mult_x2),
      .core_ratio(core_ratio), .sys_ratio(sys_ratio),
      .core_en(core_en), .sys_en(sys_en)
   );

   always @(posedge clk) begin
      if (core_en) core_pulses <= core_pulses + 1;
      if (sys_en)  sys_pulses  <= sys_pulses + 1;
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic a, logic [15:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd_check(logic a, int exp, string req);
      @(negedge clk); reg_addr = a; #1;
      check(req, int'(reg_rdata), exp);
   endtask

   task automatic pulse_apply();
      @(negedge clk); apply = 1'b1;
      @(negedge clk); apply = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rd_check(1'b1, 16'h0040, "R1 div readback");
      rd_check(1'b0, 16'h000A, "R1 ctrl readback");
      check("R1 core_ratio", core_ratio, 1);
      check("R1 sys_ratio", sys_ratio, 4);
      check("R1 busy", busy, 0);
      check("R1 vco", vco_mult_x2, 20);
   endtask

   task automatic t_core_sel();
      for (int s = 0; s < 4; s++) begin
         wr_reg(1'b1, 16'hF0 | 16'(s));
         check("R2 core_ratio", core_ratio, 1 << s);
         check("R5 sys_ratio kept 15", sys_ratio, 15);
      end
   endtask

   task automatic t_sys_sel();
      wr_reg(1'b1, 16'h0070);
      check("R3 sys 7", sys_ratio, 7);
      wr_reg(1'b1, 16'h00F0);
      check("R3 sys 15", sys_ratio, 15);
      wr_reg(1'b1, 16'h0000);
      check("R3 sys 0 as 1", sys_ratio, 1);
      rd_check(1'b1, 16'h0010, "R3 readback of 0");
   endtask

   task automatic t_clamp();
      wr_reg(1'b1, 16'h0023);
      check("R4 sys raised", sys_ratio, 8);
      check("R4 core", core_ratio, 8);
      rd_check(1'b1, 16'h0083, "R4 clamped readback");
      wr_reg(1'b1, 16'h0032);
      check("R4 sys raised to 4", sys_ratio, 4);
      wr_reg(1'b1, 16'h0052);
      check("R4 sys above core kept", sys_ratio, 5);
   endtask

   task automatic t_stage_apply();
      int n;
      wr_reg(1'b0, 16'h0000);
      rd_check(1'b0, 16'h0000, "R6 staged readback");
      check("R6 vco held", vco_mult_x2, 20);
      check("R6 busy idle", busy, 0);
      pulse_apply();
      check("R8 select 0 is 64", vco_mult_x2, 128);
      count_busy(n);
      check("R7 busy length", n, 16);
      pulse_apply();
      wr_reg(1'b0, 16'h013F);
      pulse_apply();
      check("R7 apply in busy ignored", vco_mult_x2, 128);
      count_busy(n);
      check("R7 busy not extended", n, 11);
      check("R7 vco after ignored apply", vco_mult_x2, 128);
      pulse_apply();
      check("R8 63 halved", vco_mult_x2, 63);
      count_busy(n);
      wr_reg(1'b0, 16'h0100);
      check("R6 vco before apply", vco_mult_x2, 63);
      pulse_apply();
      check("R8 0 halved is 32x", vco_mult_x2, 64);
      count_busy(n);
   endtask

   task automatic t_enables();
      int c0, s0;
      wr_reg(1'b1, 16'h0061);
      c0 = core_pulses; s0 = sys_pulses;
      ticks(12);
      check("R9 core pulses ratio 2", core_pulses - c0, 6);
      check("R9 sys pulses ratio 6", sys_pulses - s0, 2);
      wr_reg(1'b1, 16'h0010);
      c0 = core_pulses; s0 = sys_pulses;
      ticks(5);
      check("R9 core pulses ratio 1", core_pulses - c0, 5);
      check("R9 sys pulses ratio 1", sys_pulses - s0, 5);
      c0 = core_pulses;
      repeat (6) @(negedge clk);
      check("R9 no pulse without tick", core_pulses - c0, 0);
   endtask

   task automatic t_restart();
      int s0;
      wr_reg(1'b1, 16'h0030);
      ticks(2);
      wr_reg(1'b1, 16'h0050);
      s0 = sys_pulses;
      ticks(4);
      check("R10 no early pulse", sys_pulses - s0, 0);
      ticks(1);
      check("R10 first pulse on 5th tick", sys_pulses - s0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_core_sel();
      t_sys_sel();
      t_clamp();
      t_stage_apply();
      t_enables();
      t_restart();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule